// File: doc/BRIEF.md
# Microcoded Bus Datapath Core

This block is the 32-bit execution datapath of a microprogrammed processor. It has no sequencer of its own. Every cycle, a set of control fields picks one register to drive a single source bus, B. The ALU combines that bus with a holding register that always feeds its other input. A shifter stage follows the ALU. Its result is broadcast on a result bus, C, and every register whose write-enable bit is set captures the result on the rising edge that ends the cycle.

Status flags for negative and zero results are registered so that a later cycle can branch on them. Two strobes let an external memory interface load the word data register and the byte buffer directly. The address, word data and instruction pointer registers are brought out as ports for that interface.

Top module: `mdp_core`

## Requirements
- R1: `bsrc_sel` picks the single B-bus driver: 0 word data, 1 instruction pointer, 2 byte buffer sign-extended, 3 byte buffer zero-extended, 4 stack pointer, 5 frame base, 6 constant-pool base, 7 top-of-stack copy, 8 scratch. Codes 9 to 15 leave the B bus at zero.
- R2: `cwr_mask` bit positions are 0 hold register, 1 scratch, 2 top-of-stack copy, 3 constant-pool base, 4 frame base, 5 stack pointer, 6 instruction pointer, 7 word data, 8 address. In one cycle, every register with its bit set captures the same C value, and every register with its bit clear keeps its value.
- R3: The hold register is always the ALU A operand. It changes only when mask bit 0 is set.
- R4: `alu_ctl` bits are [5] F0, [4] F1, [3] enable A, [2] enable B, [1] invert A, [0] carry-in. F0F1 selects: 00 gives AND, 01 gives OR, 10 gives NOT B, 11 gives the sum plus carry-in. The encodings and their functions are: 0x18 A, 0x14 B, 0x1A ~A, 0x2C ~B, 0x3C A+B, 0x3D A+B+1, 0x39 A+1, 0x35 B+1, 0x3F B-A, 0x36 B-1, 0x3B -A, 0x0C A&B, 0x1C A|B, 0x10 0, 0x31 1, 0x32 -1.
- R5: The shifter takes the ALU result. `sh_sll8` shifts it left logically by 8. `sh_sra1` shifts it right arithmetically by 1. With both set, the left shift wins. With neither set, the result passes unchanged.
- R6: Each cycle, `flag_n` and `flag_z` capture the sign bit of the ALU result and whether that result is zero. The result is taken before the shifter.
- R7: The byte buffer reads as a sign-extended value through B code 2 and as a zero-extended value through B code 3.
- R8: `mdr_load` writes `mdr_in` into the word data register, and it takes priority over mask bit 7 in the same cycle. `mbr_load` writes `mbr_in` into the byte buffer.
- R9: While `rst_n` is low, every register and both flags are zero.
- R10: `mar_q`, `mdr_q` and `pc_q` show the address, word data and instruction pointer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsrc_sel | input | 4 | B-bus source code |
| cwr_mask | input | 9 | C-bus write enables |
| alu_ctl | input | 6 | ALU function field |
| sh_sll8 | input | 1 | Shift result left by 8 |
| sh_sra1 | input | 1 | Shift result right arithmetically by 1 |
| mdr_load | input | 1 | Load word data register from memory |
| mdr_in | input | 32 | Word read from memory |
| mbr_load | input | 1 | Load byte buffer from memory |
| mbr_in | input | 8 | Byte fetched from memory |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| mar_q | output | 32 | Address register |
| mdr_q | output | 32 | Word data register |
| pc_q | output | 32 | Instruction pointer register |

## Verification
The assertions take for granted that every control input is a known value at each rising edge. A cycle whose flags matter is judged by the flags captured on the edge that ends it. The assertions also take for granted that the result of an ALU code outside the listed set is never relied on.

The stimulus changes inputs only on falling edges and uses only the listed ALU codes. It reaches any internal register only by routing it over the B bus into the address register, so every result is read at the ports.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int DW     = 32;
  localparam int BYTEW  = 8;
  localparam int SELW   = 4;
  localparam int NSRC   = 9;
  localparam int NREG   = 9;
  localparam int CTLW   = 6;

  // C-bus register indices (bit positions of the write mask)
  localparam int RI_H   = 0;
  localparam int RI_OPC = 1;
  localparam int RI_TOS = 2;
  localparam int RI_CPP = 3;
  localparam int RI_LV  = 4;
  localparam int RI_SP  = 5;
  localparam int RI_PC  = 6;
  localparam int RI_MDR = 7;
  localparam int RI_MAR = 8;

  typedef enum logic [SELW-1:0] {
    BS_MDR  = 4'd0,
    BS_PC   = 4'd1,
    BS_BYTS = 4'd2,
    BS_BYTU = 4'd3,
    BS_SP   = 4'd4,
    BS_LV   = 4'd5,
    BS_CPP  = 4'd6,
    BS_TOS  = 4'd7,
    BS_OPC  = 4'd8
  } bsrc_e;

  typedef struct packed {
    logic f0;
    logic f1;
    logic ena;
    logic enb;
    logic inva;
    logic inc;
  } alu_ctl_t;

  localparam logic [CTLW-1:0] OPC_ZERO = 6'h10;
endpackage

// File: rtl/dp_bsel.sv
module dp_bsel
  import dp_pkg::*;
#(
  parameter int W  = DW,
  parameter int NS = NSRC,
  parameter int SW = SELW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SW-1:0]       sel,
  input  logic [NS-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);
  logic [NS-1:0] drv_en;

  // One-hot decode of the source code
  generate
    for (genvar g = 0; g < NS; g++) begin : g_dec
      assign drv_en[g] = (sel == SW'(g));
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < NS; i++) begin
      bus = bus | (src[i] & {W{drv_en[i]}});
    end
  end

  // R1: a valid code enables exactly one driver, an unused code none
  a_r1_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (sel < SW'(NS)) |-> $onehot(drv_en));
  a_r1_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SW'(NS)) |-> (bus == '0));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_ctl_t     ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;

  always_comb begin
    a_op = ctl.ena ? a : '0;
    if (ctl.inva) a_op = ~a_op;
    b_op = ctl.enb ? b : '0;
    unique case ({ctl.f0, ctl.f1})
      2'b00:   res = a_op & b_op;
      2'b01:   res = a_op | b_op;
      2'b10:   res = ~b_op;
      default: res = a_op + b_op + W'(ctl.inc);
    endcase
  end

  // R4: the constant-zero code yields zero whatever the operands
  always_comb begin
    if (ctl == OPC_ZERO) a_r4_const_zero: assert (res == '0);
  end
endmodule

// File: rtl/dp_shift.sv
module dp_shift
  import dp_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         sll8,
  input  logic         sra1,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_comb begin
    if (sll8)      dout = din << 8;
    else if (sra1) dout = {din[W-1], din[W-1:1]};
    else           dout = din;
  end

  // R5: the arithmetic right shift keeps the sign bit
  always_comb begin
    if (sra1 && !sll8) a_r5_sra_sign: assert (dout[W-1] == din[W-1]);
  end
endmodule

// File: rtl/mdp_core.sv
module mdp_core
  import dp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SELW-1:0]  bsrc_sel,
  input  logic [NREG-1:0]  cwr_mask,
  input  logic [CTLW-1:0]  alu_ctl,
  input  logic             sh_sll8,
  input  logic             sh_sra1,
  input  logic             mdr_load,
  input  logic [DW-1:0]    mdr_in,
  input  logic             mbr_load,
  input  logic [BYTEW-1:0] mbr_in,
  output logic             flag_n,
  output logic             flag_z,
  output logic [DW-1:0]    mar_q,
  output logic [DW-1:0]    mdr_q,
  output logic [DW-1:0]    pc_q
);
  localparam int EXTW = DW - BYTEW;

  logic [DW-1:0]              rf_q [NREG];
  logic [DW-1:0]              rf_d [NREG];
  logic [NREG-1:0]            rf_en;
  logic [BYTEW-1:0]           mbr_q;
  logic [BYTEW-1:0]           mbr_d;
  logic                       mbr_en;
  logic [NSRC-1:0][DW-1:0]    b_src;
  logic [DW-1:0]              b_bus;
  logic [DW-1:0]              alu_res;
  logic [DW-1:0]              c_bus;
  logic                       fn_d;
  logic                       fz_d;

  // B-bus source vector, indexed by the source code
  always_comb begin
    b_src          = '0;
    b_src[BS_MDR]  = rf_q[RI_MDR];
    b_src[BS_PC]   = rf_q[RI_PC];
    b_src[BS_BYTS] = {{EXTW{mbr_q[BYTEW-1]}}, mbr_q};
    b_src[BS_BYTU] = {{EXTW{1'b0}}, mbr_q};
    b_src[BS_SP]   = rf_q[RI_SP];
    b_src[BS_LV]   = rf_q[RI_LV];
    b_src[BS_CPP]  = rf_q[RI_CPP];
    b_src[BS_TOS]  = rf_q[RI_TOS];
    b_src[BS_OPC]  = rf_q[RI_OPC];
  end

  dp_bsel #(.W(DW), .NS(NSRC), .SW(SELW)) u_bsel (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (bsrc_sel),
    .src   (b_src),
    .bus   (b_bus)
  );

  dp_alu #(.W(DW)) u_alu (
    .ctl (alu_ctl_t'(alu_ctl)),
    .a   (rf_q[RI_H]),
    .b   (b_bus),
    .res (alu_res)
  );

  dp_shift #(.W(DW)) u_shift (
    .sll8 (sh_sll8),
    .sra1 (sh_sra1),
    .din  (alu_res),
    .dout (c_bus)
  );

  // Register file: next-state and enables, then flops
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == RI_MDR) begin : g_mdr
        always_comb begin
          rf_en[g] = cwr_mask[g] | mdr_load;
          rf_d[g]  = mdr_load ? mdr_in : c_bus;
        end
      end else begin : g_plain
        always_comb begin
          rf_en[g] = cwr_mask[g];
          rf_d[g]  = c_bus;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rf_q[g] <= '0;
        else if (rf_en[g]) rf_q[g] <= rf_d[g];
      end
    end
  endgenerate

  always_comb begin
    mbr_en = mbr_load;
    mbr_d  = mbr_in;
    fn_d   = alu_res[DW-1];
    fz_d   = (alu_res == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mbr_q <= '0;
    else if (mbr_en) mbr_q <= mbr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_n <= fn_d;
      flag_z <= fz_d;
    end
  end

  assign mar_q = rf_q[RI_MAR];
  assign mdr_q = rf_q[RI_MDR];
  assign pc_q  = rf_q[RI_PC];

  // R2: two destinations written together hold the same value
  a_r2_parallel_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_mask[RI_MAR] && cwr_mask[RI_PC]) |=> (mar_q == pc_q));
  // R3: the hold register keeps its value unless its bit is set
  a_r3_h_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cwr_mask[RI_H] |=> $stable(rf_q[RI_H]));
  // R6: the zero flag follows the ALU result of the previous cycle
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_z == $past(alu_res == '0)));
  // R8: a memory load wins over a C-bus write of the word data register
  a_r8_mdr_priority: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_load |=> (mdr_q == $past(mdr_in)));
endmodule

// File: tb/tb_mdp_core.sv
`timescale 1ns/1ps
module tb_mdp_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bsrc_sel;
  logic [8:0]  cwr_mask;
  logic [5:0]  alu_ctl;
  logic        sh_sll8, sh_sra1, mdr_load, mbr_load;
  logic [31:0] mdr_in;
  logic [7:0]  mbr_in;
  logic        flag_n, flag_z;
  logic [31:0] mar_q, mdr_q, pc_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdp_core dut (
    .clk(clk), .rst_n(rst_n), .bsrc_sel(bsrc_sel), .cwr_mask(cwr_mask),
    .alu_ctl(alu_ctl), .sh_sll8(sh_sll8), .sh_sra1(sh_sra1),
    .mdr_load(mdr_load), .mdr_in(mdr_in), .mbr_load(mbr_load),
    .mbr_in(mbr_in), .flag_n(flag_n), .flag_z(flag_z),
    .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q)
  );

  localparam logic [5:0] K_A = 6'h18, K_B = 6'h14, K_NA = 6'h1A, K_NB = 6'h2C,
    K_ADD = 6'h3C, K_ADD1 = 6'h3D, K_INCA = 6'h39, K_INCB = 6'h35,
    K_SUB = 6'h3F, K_DECB = 6'h36, K_NEGA = 6'h3B, K_AND = 6'h0C,
    K_OR = 6'h1C, K_ZERO = 6'h10, K_ONE = 6'h31, K_MONE = 6'h32;
  localparam logic [8:0] M_H = 9'h001, M_OPC = 9'h002, M_TOS = 9'h004,
    M_CPP = 9'h008, M_LV = 9'h010, M_SP = 9'h020, M_PC = 9'h040,
    M_MDR = 9'h080, M_MAR = 9'h100;

  typedef struct packed {
    logic [5:0]  op;
    logic        sll;
    logic        sra;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{K_A,    1'b0, 1'b0, 32'h12345678, 32'hDEADBEEF},
    '{K_B,    1'b0, 1'b0, 32'h12345678, 32'hDEADBEEF},
    '{K_NA,   1'b0, 1'b0, 32'h0000FFFF, 32'h00000001},
    '{K_NB,   1'b0, 1'b0, 32'h00000003, 32'hFFFFFFFF},
    '{K_ADD,  1'b0, 1'b0, 32'h7FFFFFFF, 32'h00000001},
    '{K_ADD1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000000},
    '{K_INCA, 1'b0, 1'b0, 32'h000000FF, 32'h55555555},
    '{K_INCB, 1'b0, 1'b0, 32'h55555555, 32'hFFFFFFFE},
    '{K_SUB,  1'b0, 1'b0, 32'h00000005, 32'h00000005},
    '{K_SUB,  1'b0, 1'b0, 32'h0000000A, 32'h00000003},
    '{K_DECB, 1'b0, 1'b0, 32'h12121212, 32'h00000000},
    '{K_NEGA, 1'b0, 1'b0, 32'h00000001, 32'h77777777},
    '{K_AND,  1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00},
    '{K_OR,   1'b0, 1'b0, 32'hF0F0F0F0, 32'h0F0F0F00},
    '{K_ZERO, 1'b0, 1'b0, 32'hABCDEF01, 32'h10FEDCBA},
    '{K_ONE,  1'b0, 1'b0, 32'hABCDEF01, 32'h10FEDCBA},
    '{K_MONE, 1'b0, 1'b0, 32'h00000000, 32'h00000000},
    '{K_ADD,  1'b1, 1'b0, 32'h00ABCDEF, 32'h00000010},
    '{K_B,    1'b0, 1'b1, 32'h00000000, 32'h80000010}
  };

  function automatic logic [31:0] ref_alu(input logic [5:0] op,
                                          input logic [31:0] a, b);
    case (op)
      K_A:    return a;
      K_B:    return b;
      K_NA:   return ~a;
      K_NB:   return ~b;
      K_ADD:  return a + b;
      K_ADD1: return a + b + 32'd1;
      K_INCA: return a + 32'd1;
      K_INCB: return b + 32'd1;
      K_SUB:  return b - a;
      K_DECB: return b - 32'd1;
      K_NEGA: return 32'd0 - a;
      K_AND:  return a & b;
      K_OR:   return a | b;
      K_ZERO: return 32'd0;
      K_ONE:  return 32'd1;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] ref_shift(input logic sll, sra,
                                            input logic [31:0] v);
    if (sll) return v << 8;
    if (sra) return $unsigned($signed(v) >>> 1);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bsrc_sel = 4'd15; cwr_mask = '0; alu_ctl = K_ZERO;
    sh_sll8 = 0; sh_sra1 = 0; mdr_load = 0; mdr_in = '0;
    mbr_load = 0; mbr_in = '0;
  endtask

  // One datapath cycle: drive on the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic [3:0] bs, input logic [8:0] cm,
                      input logic [5:0] op, input logic sll, sra);
    @(negedge clk);
    idle_inputs();
    bsrc_sel = bs; cwr_mask = cm; alu_ctl = op; sh_sll8 = sll; sh_sra1 = sra;
    @(posedge clk); #1;
  endtask

  task automatic mem_word(input logic [31:0] w);
    @(negedge clk);
    idle_inputs();
    mdr_load = 1; mdr_in = w;
    @(posedge clk); #1;
  endtask

  task automatic mem_byte(input logic [7:0] v);
    @(negedge clk);
    idle_inputs();
    mbr_load = 1; mbr_in = v;
    @(posedge clk); #1;
  endtask

  // Copy a B source into the address register and check it
  task automatic peek(input string req, input logic [3:0] bs, input logic [31:0] exp);
    step(bs, M_MAR, K_B, 0, 0);
    chk(req, mar_q, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 mar", mar_q, '0);
    chk("R9 mdr", mdr_q, '0);
    chk("R9 pc", pc_q, '0);
    chk("R9 flags", {30'd0, flag_n, flag_z}, '0);
    @(negedge clk);
    rst_n = 1;

    // R4 R5 R6 R10: table of ALU and shifter vectors
    for (int i = 0; i < NV; i++) begin
      logic [31:0] raw;
      mem_word(VECS[i].a);
      step(4'd0, M_H, K_B, 0, 0);
      mem_word(VECS[i].b);
      step(4'd0, M_MAR, VECS[i].op, VECS[i].sll, VECS[i].sra);
      raw = ref_alu(VECS[i].op, VECS[i].a, VECS[i].b);
      chk(VECS[i].sll || VECS[i].sra ? "R5 shift" : "R4 alu", mar_q,
          ref_shift(VECS[i].sll, VECS[i].sra, raw));
      chk("R6 flags", {30'd0, flag_n, flag_z}, {30'd0, raw[31], raw == 32'd0});
    end

    // R5: both shift controls set, left shift wins
    mem_word(32'h000000F1);
    step(4'd0, M_MAR, K_B, 1, 1);
    chk("R5 both", mar_q, 32'h0000F100);

    // R2: broadcast one value to all nine registers
    mem_word(32'hCAFEF00D);
    step(4'd0, 9'h1FF, K_B, 0, 0);
    chk("R2 pc", pc_q, 32'hCAFEF00D);
    chk("R2 mar", mar_q, 32'hCAFEF00D);
    chk("R10 mdr", mdr_q, 32'hCAFEF00D);
    peek("R2 sp", 4'd4, 32'hCAFEF00D);
    peek("R2 lv", 4'd5, 32'hCAFEF00D);
    peek("R2 cpp", 4'd6, 32'hCAFEF00D);
    peek("R2 tos", 4'd7, 32'hCAFEF00D);
    peek("R2 opc", 4'd8, 32'hCAFEF00D);
    step(4'd15, M_MAR, K_A, 0, 0);
    chk("R3 h via A", mar_q, 32'hCAFEF00D);

    // R2 R3: only top-of-stack written; neighbours and H hold
    mem_word(32'h01020304);
    step(4'd0, M_TOS, K_ADD, 0, 0);
    peek("R2 tos new", 4'd7, 32'hCAFEF00D + 32'h01020304);
    peek("R2 lv held", 4'd5, 32'hCAFEF00D);
    step(4'd15, M_MAR, K_A, 0, 0);
    chk("R3 h held", mar_q, 32'hCAFEF00D);

    // R1: unused source codes drive zero
    step(4'd12, M_MAR, K_B, 0, 0);
    chk("R1 unused", mar_q, 32'h0);
    chk("R1 zero flag", {31'd0, flag_z}, 32'd1);
    peek("R1 pc code", 4'd1, 32'hCAFEF00D);

    // R7 R8: byte buffer signed and unsigned reads
    mem_byte(8'h85);
    peek("R7 signed", 4'd2, 32'hFFFFFF85);
    peek("R7 unsigned", 4'd3, 32'h00000085);
    mem_byte(8'h7F);
    peek("R7 signed pos", 4'd2, 32'h0000007F);

    // R8: memory load beats a C-bus write of the word data register
    @(negedge clk);
    idle_inputs();
    bsrc_sel = 4'd1; cwr_mask = M_MDR; alu_ctl = K_B;
    mdr_load = 1; mdr_in = 32'h11111111;
    @(posedge clk); #1;
    chk("R8 priority", mdr_q, 32'h11111111);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule